// File: doc/BRIEF.md
# ATM Cell Source with Idle Fill

This block supplies a continuous stream of 53-byte ATM cells, one byte at a time, to the framer's payload mapper on the transmit side. User cells are written byte by byte into an internal buffer that holds four cells. At every cell boundary the block chooses what to send next. If the buffer holds a complete user cell, that cell is sent. If it does not and filler generation is enabled, an idle or unassigned filler cell is sent instead. If neither applies, the output stays invalid until a complete user cell arrives.

Filler cells take their five header bytes from a configuration word. Their 48 payload bytes follow a selectable pattern: a constant byte, a value that rises by one from one filler cell to the next, or a value that rises by one from each byte to the next inside the cell. The fifth header byte sits where the HEC would be. The block passes it through unchanged: the buffered byte for user cells, the configured byte for filler cells. Two counters record how many filler cells and how many user cells have been fully sent. Each counter either wraps or saturates, as one configuration bit selects, and a synchronous clear input resets both.

Top module: `atm_cell_source`

## Requirements
- R1: The buffer accepts a byte only while `wr_ready` is high. `wr_ready` falls once four full cells (212 bytes) are stored and rises again when bytes are read out.
- R2: At a cell boundary, if a complete user cell has been stored for at least one full cycle, that cell is chosen (`out_is_fill` low), and its 53 bytes come out in the order they were written.
- R3: At a cell boundary with no complete user cell stored and `cfg_fill_en` high, a filler cell is started with `out_is_fill` high.
- R4: With `cfg_fill_en` low and no complete user cell stored, no filler cell is started and `out_valid` stays low.
- R5: Filler header byte n (n = 0..4) equals `cfg_hdr[(4-n)*8 +: 8]`. Byte 0 is sent first, and byte 4 is the HEC-position byte.
- R6: For `cfg_pat_mode` 0 and 3, every filler payload byte equals `cfg_pat_val`.
- R7: For `cfg_pat_mode` 1, every payload byte of a filler cell equals `cfg_pat_val + s` modulo 256. Here s is the number of filler cells completed since reset or the last clear.
- R8: For `cfg_pat_mode` 2, payload byte k (k = 0..47) of a filler cell equals `cfg_pat_val + k` modulo 256.
- R9: A started cell is sent whole, 53 bytes, and its kind never changes mid-cell. `out_soc` is high on its first byte. Data and kind hold while `out_ready` is low.
- R10: `fill_cnt` and `user_cnt` each rise by one on the edge where the last byte of a filler or user cell is taken. When `cfg_cnt_sat` is low they wrap from all ones to zero.
- R11: When `cfg_cnt_sat` is high, a counter at all ones stays at all ones.
- R12: `cnt_clr` zeroes both counters and the per-cell pattern step on the next edge, and it overrides a same-cycle increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | User cell byte write strobe |
| wr_data | input | 8 | User cell byte |
| wr_ready | output | 1 | Buffer has room for a byte |
| out_ready | input | 1 | Mapper takes the current byte |
| out_valid | output | 1 | Output byte is valid |
| out_data | output | 8 | Output byte |
| out_soc | output | 1 | First byte of a cell |
| out_is_fill | output | 1 | Current cell is a filler cell |
| cfg_fill_en | input | 1 | Enable filler generation |
| cfg_hdr | input | 40 | Filler header bytes, first byte in the top octet |
| cfg_pat_mode | input | 2 | Filler payload pattern select |
| cfg_pat_val | input | 8 | Filler payload base value |
| cfg_cnt_sat | input | 1 | Counters saturate (1) or wrap (0) |
| cnt_clr | input | 1 | Synchronous clear of counters and pattern step |
| fill_cnt | output | CNT_W | Filler cells sent |
| user_cnt | output | CNT_W | User cells sent |

## Verification
The output byte and its flags are driven straight from state. A new cell shows on the edge after the cycle in which the choice is made, and that choice sees a user cell only from the edge after its last byte was written. So a user cell whose final byte enters on edge N can start no earlier than the output seen after edge N+1. The bench keeps this rule when it predicts the kind of every new cell, using a cycle stamp taken on each completed write. Counter values and clears are due one edge after the last-byte transfer or the clear request. The bench updates its expected counts at the sample before that edge and compares them at the sample after it. Inputs change one time unit after a rising edge, and every comparison is made at the falling edge.

// File: rtl/atm_src_pkg.sv
// Shared constants and types for the ATM cell source.
// Assumes standard ATM cells: 5 header bytes followed by 48 payload bytes.
package atm_src_pkg;
    localparam int ATM_CELL_BYTES = 53;
    localparam int ATM_HDR_BYTES  = 5;

    // Kind of the cell currently on the output
    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_USER = 2'd1,
        SRC_FILL = 2'd2
    } src_kind_e;

    // Filler payload pattern selection
    typedef enum logic [1:0] {
        PAT_FIXED     = 2'd0,
        PAT_CELL_INC  = 2'd1,
        PAT_BYTE_INC  = 2'd2,
        PAT_FIXED_ALT = 2'd3
    } pat_mode_e;
endpackage

// File: rtl/acs_cell_fifo.sv
// Byte-wide elastic buffer sized for CELLS whole cells.
// Tracks how many complete cells have been written and not yet claimed.
// Assumes rd_en is only raised when the head byte belongs to a claimed cell,
// and take_cell only when cell_avail is high.
module acs_cell_fifo #(
    parameter int CELLS      = 4,
    parameter int CELL_BYTES = 53
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       wr_ready,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    input  logic       take_cell,
    output logic       cell_avail
);
    localparam int DEPTH = CELLS * CELL_BYTES;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int BW    = $clog2(CELL_BYTES);
    localparam int NW    = $clog2(CELLS + 1);
    localparam logic [AW-1:0] PTR_LAST  = AW'(DEPTH - 1);
    localparam logic [BW-1:0] BYTE_LAST = BW'(CELL_BYTES - 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] occ;
    logic [BW-1:0] wbyte;
    logic [NW-1:0] ncell;
    logic          wr_fire, cell_done;

    assign wr_ready   = (occ < CW'(DEPTH));
    assign wr_fire    = wr_en && wr_ready;
    assign cell_done  = wr_fire && (wbyte == BYTE_LAST);
    assign rd_data    = mem[rd_ptr];
    assign cell_avail = (ncell != '0);

    // Store accepted bytes (storage array needs no reset)
    always_ff @(posedge clk) begin
        if (wr_fire) mem[wr_ptr] <= wr_data;
    end

    // Advance write/read pointers with wrap at the buffer depth
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_fire) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_en)   rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Track byte occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else begin
            case ({wr_fire, rd_en})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    // Position of the next written byte inside its cell
    always_ff @(posedge clk) begin
        if (!rst_n)       wbyte <= '0;
        else if (wr_fire) wbyte <= (wbyte == BYTE_LAST) ? '0 : wbyte + 1'b1;
    end

    // Number of complete, unclaimed cells
    always_ff @(posedge clk) begin
        if (!rst_n) ncell <= '0;
        else begin
            case ({cell_done, take_cell})
                2'b10:   ncell <= ncell + 1'b1;
                2'b01:   ncell <= ncell - 1'b1;
                default: ncell <= ncell;
            endcase
        end
    end
endmodule

// File: rtl/acs_fill_gen.sv
// Combinational filler byte generator.
// Given the byte index inside a cell, returns the configured header byte or
// the payload byte of the selected pattern. All arithmetic wraps modulo 256.
module acs_fill_gen
    import atm_src_pkg::*;
#(
    parameter int CELL_BYTES = ATM_CELL_BYTES,
    parameter int HDR_BYTES  = ATM_HDR_BYTES,
    parameter int IDX_W      = $clog2(CELL_BYTES)
) (
    input  logic [IDX_W-1:0]       idx,
    input  logic [HDR_BYTES*8-1:0] hdr,
    input  logic [1:0]             mode,
    input  logic [7:0]             base,
    input  logic [7:0]             seq,
    output logic [7:0]             fill_byte
);
    logic [7:0] pay_idx;

    assign pay_idx = 8'(idx) - 8'(HDR_BYTES);

    // Pick the header byte or the pattern byte for this position
    always_comb begin
        fill_byte = base;
        if (idx < IDX_W'(HDR_BYTES)) begin
            for (int i = 0; i < HDR_BYTES; i++) begin
                if (idx == IDX_W'(i)) fill_byte = hdr[(HDR_BYTES-1-i)*8 +: 8];
            end
        end else begin
            case (pat_mode_e'(mode))
                PAT_CELL_INC: fill_byte = base + seq;
                PAT_BYTE_INC: fill_byte = base + pay_idx;
                default:      fill_byte = base;
            endcase
        end
    end
endmodule

// File: rtl/acs_sat_counter.sv
// Event counter with synchronous clear and a selectable saturate/wrap mode.
// Clear has priority over increment.
module acs_sat_counter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         sat,
    output logic [W-1:0] cnt
);
    // Count events, holding at all ones when saturating
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          cnt <= '0;
        else if (inc && !(sat && (&cnt))) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/atm_cell_source.sv
// ATM cell source with idle fill.
// Buffers written user cells and emits a gap-free byte stream of whole cells,
// inserting register-defined filler cells when no user cell is complete.
// Assumes the writer delivers whole 53-byte cells in order; the byte in the
// HEC position is passed through untouched.
module atm_cell_source
    import atm_src_pkg::*;
#(
    parameter int BUF_CELLS = 4,
    parameter int CNT_W     = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             wr_ready,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_soc,
    output logic             out_is_fill,
    input  logic             cfg_fill_en,
    input  logic [39:0]      cfg_hdr,
    input  logic [1:0]       cfg_pat_mode,
    input  logic [7:0]       cfg_pat_val,
    input  logic             cfg_cnt_sat,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] fill_cnt,
    output logic [CNT_W-1:0] user_cnt
);
    localparam int IDX_W = $clog2(ATM_CELL_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ATM_CELL_BYTES - 1);
    localparam int N_CNT = 2;

    src_kind_e        kind_q, kind_pick;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       fill_seq;
    logic [7:0]       fifo_byte, fill_byte;
    logic             cell_avail, xfer, last, boundary, take_cell, rd_en;
    logic [N_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_val [N_CNT];

    acs_cell_fifo #(
        .CELLS      (BUF_CELLS),
        .CELL_BYTES (ATM_CELL_BYTES)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .rd_en      (rd_en),
        .rd_data    (fifo_byte),
        .take_cell  (take_cell),
        .cell_avail (cell_avail)
    );

    acs_fill_gen #(
        .CELL_BYTES (ATM_CELL_BYTES),
        .HDR_BYTES  (ATM_HDR_BYTES),
        .IDX_W      (IDX_W)
    ) u_fill (
        .idx       (idx_q),
        .hdr       (cfg_hdr),
        .mode      (cfg_pat_mode),
        .base      (cfg_pat_val),
        .seq       (fill_seq),
        .fill_byte (fill_byte)
    );

    assign out_valid   = (kind_q != SRC_IDLE);
    assign out_is_fill = (kind_q == SRC_FILL);
    assign out_soc     = out_valid && (idx_q == '0);
    assign out_data    = (kind_q == SRC_USER) ? fifo_byte : fill_byte;
    assign xfer        = out_valid && out_ready;
    assign last        = (idx_q == IDX_LAST);
    assign boundary    = (kind_q == SRC_IDLE) || (xfer && last);
    assign take_cell   = boundary && cell_avail;
    assign rd_en       = xfer && (kind_q == SRC_USER);

    // Choose the next cell kind: user cell first, then filler if enabled
    always_comb begin
        if (cell_avail)       kind_pick = SRC_USER;
        else if (cfg_fill_en) kind_pick = SRC_FILL;
        else                  kind_pick = SRC_IDLE;
    end

    // Sequence through the bytes of the current cell
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= SRC_IDLE;
            idx_q  <= '0;
        end else if (boundary) begin
            kind_q <= kind_pick;
            idx_q  <= '0;
        end else if (xfer) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Per-cell pattern step: one per completed filler cell
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr)                     fill_seq <= '0;
        else if (xfer && last && kind_q == SRC_FILL) fill_seq <= fill_seq + 1'b1;
    end

    assign cnt_inc[0] = xfer && last && (kind_q == SRC_FILL);
    assign cnt_inc[1] = xfer && last && (kind_q == SRC_USER);

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        acs_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (cnt_inc[g]),
            .sat   (cfg_cnt_sat),
            .cnt   (cnt_val[g])
        );
    end

    assign fill_cnt = cnt_val[0];
    assign user_cnt = cnt_val[1];
endmodule

// File: rtl/atm_cell_source_chk.sv
// Property checker for atm_cell_source, attached by bind.
module atm_cell_source_chk #(
    parameter int CNT_W = 24,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_soc,
    input logic             out_is_fill,
    input logic             cfg_fill_en,
    input logic             cfg_cnt_sat,
    input logic             cnt_clr,
    input logic [CNT_W-1:0] fill_cnt,
    input logic [CNT_W-1:0] user_cnt,
    input logic [IDX_W-1:0] idx_q
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(52);

    // R9: a stalled byte is held unchanged
    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_is_fill));

    // R9: a cell continues without change of kind until its last byte
    a_r9_whole_cell: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && idx_q != IDX_LAST |=> out_valid && !out_soc && $stable(out_is_fill));

    // R4: a filler cell only starts after a cycle with filler enabled
    a_r4_fill_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc && out_is_fill |-> $past(cfg_fill_en) || $past(out_soc && out_is_fill));

    // R12: clear empties both counters
    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> fill_cnt == '0 && user_cnt == '0);

    // R11: saturated counters stay at all ones
    a_r11_fill_sat: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cnt_sat && (&fill_cnt) && !cnt_clr |=> &fill_cnt);
    a_r11_user_sat: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cnt_sat && (&user_cnt) && !cnt_clr |=> &user_cnt);

    // R10: counters move by at most one per edge
    a_r10_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> fill_cnt == $past(fill_cnt) || fill_cnt == CNT_W'($past(fill_cnt) + 1'b1));
    a_r10_user_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> user_cnt == $past(user_cnt) || user_cnt == CNT_W'($past(user_cnt) + 1'b1));
endmodule

bind atm_cell_source atm_cell_source_chk #(
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_soc     (out_soc),
    .out_is_fill (out_is_fill),
    .cfg_fill_en (cfg_fill_en),
    .cfg_cnt_sat (cfg_cnt_sat),
    .cnt_clr     (cnt_clr),
    .fill_cnt    (fill_cnt),
    .user_cnt    (user_cnt),
    .idx_q       (idx_q)
);

// File: tb/atm_cell_source_tb.sv
`timescale 1ns/1ps
module atm_cell_source_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 6;
    localparam int CMAX       = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             wr_ready;
    logic             out_ready = 1'b0;
    logic             out_valid, out_soc, out_is_fill;
    logic [7:0]       out_data;
    logic             cfg_fill_en = 1'b0;
    logic [39:0]      cfg_hdr = 40'h11_22_33_44_55;
    logic [1:0]       cfg_pat_mode = 2'd0;
    logic [7:0]       cfg_pat_val = 8'h6A;
    logic             cfg_cnt_sat = 1'b0;
    logic             cnt_clr = 1'b0;
    logic [CNT_W-1:0] fill_cnt, user_cnt;

    atm_cell_source #(.BUF_CELLS(4), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .out_soc(out_soc),
        .out_is_fill(out_is_fill), .cfg_fill_en(cfg_fill_en), .cfg_hdr(cfg_hdr),
        .cfg_pat_mode(cfg_pat_mode), .cfg_pat_val(cfg_pat_val), .cfg_cnt_sat(cfg_cnt_sat),
        .cnt_clr(cnt_clr), .fill_cnt(fill_cnt), .user_cnt(user_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    int rdy_pct = 0;
    bit mon_en = 1'b0;

    // bench model state
    int         cyc = 0;
    bit         fill_prev = 1'b0;
    logic [7:0] ubytes[$];
    int         ucomp[$];
    int         wcount = 0;
    int         exp_fill = 0, exp_user = 0;
    int         seq_m = 0;
    bit         m_started = 1'b0, m_fill = 1'b0;
    int         m_idx = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic int cinc(input int v);
        if (v == CMAX) return cfg_cnt_sat ? CMAX : 0;
        return v + 1;
    endfunction

    function automatic logic [7:0] fill_exp(input int i, input int s);
        if (i < 5) return cfg_hdr[(4-i)*8 +: 8];
        case (cfg_pat_mode)
            2'd1:    return cfg_pat_val + 8'(s);
            2'd2:    return cfg_pat_val + 8'(i - 5);
            default: return cfg_pat_val;
        endcase
    endfunction

    function automatic string fill_tag(input int i);
        if (i < 5) return "R5";
        case (cfg_pat_mode)
            2'd1:    return "R7";
            2'd2:    return "R8";
            default: return "R6";
        endcase
    endfunction

    // Edge bookkeeping: cycle stamp, accepted writes, decision-time enable, clear
    always @(posedge clk) begin
        cyc = cyc + 1;
        fill_prev = cfg_fill_en;
        if (rst_n && wr_en && wr_ready) begin
            ubytes.push_back(wr_data);
            wcount++;
            if (wcount == 53) begin
                wcount = 0;
                ucomp.push_back(cyc);
            end
        end
        if (rst_n && cnt_clr) begin
            exp_fill = 0;
            exp_user = 0;
            seq_m    = 0;
        end
    end

    // Output monitor at the falling edge
    always @(negedge clk) begin
        if (mon_en) begin
            chk(fill_cnt == CNT_W'(exp_fill), cfg_cnt_sat ? "R11 fill_cnt" : "R10 fill_cnt", fill_cnt, exp_fill);
            chk(user_cnt == CNT_W'(exp_user), cfg_cnt_sat ? "R11 user_cnt" : "R10 user_cnt", user_cnt, exp_user);
            if (!m_started) begin
                bit user_ok;
                user_ok = (ucomp.size() > 0) && (ucomp[0] <= cyc - 1);
                chk(out_valid == (user_ok || fill_prev), user_ok ? "R2 start" : (fill_prev ? "R3 start" : "R4 idle"),
                    out_valid, user_ok || fill_prev);
                if (out_valid) begin
                    chk(out_soc, "R9 soc", out_soc, 1);
                    chk(out_is_fill == !user_ok, user_ok ? "R2 kind" : "R3 kind", out_is_fill, !user_ok);
                    m_started = 1'b1;
                    m_fill    = !user_ok;
                    m_idx     = 0;
                    if (user_ok) void'(ucomp.pop_front());
                end
            end
            if (m_started) begin
                chk(out_valid, "R9 cell gap", out_valid, 1);
                chk(out_is_fill == m_fill, "R9 kind stable", out_is_fill, m_fill);
                if (out_valid && out_ready) begin
                    if (m_fill) begin
                        logic [7:0] e;
                        e = fill_exp(m_idx, seq_m);
                        chk(out_data == e, fill_tag(m_idx), out_data, e);
                    end else begin
                        logic [7:0] e;
                        e = (ubytes.size() > 0) ? ubytes.pop_front() : 8'h00;
                        chk(out_data == e, "R2 data", out_data, e);
                    end
                    m_idx++;
                    if (m_idx == 53) begin
                        m_started = 1'b0;
                        if (m_fill) begin
                            exp_fill = cinc(exp_fill);
                            seq_m    = (seq_m + 1) % 256;
                        end else begin
                            exp_user = cinc(exp_user);
                        end
                    end
                end
            end
        end
    end

    // Mapper readiness driver
    always begin
        @(posedge clk); #1;
        out_ready = ($urandom % 100) < rdy_pct;
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic write_cell(input logic [7:0] base);
        int i = 0;
        while (i < 53) begin
            step();
            if (wr_ready) begin
                wr_en   = 1'b1;
                wr_data = (i == 0) ? base : 8'($urandom);
                i++;
            end else begin
                wr_en = 1'b0;
            end
        end
        step();
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        cfg_fill_en = 1'b0;
        while (quiet < 4) begin
            step();
            if (!out_valid && ubytes.size() == 0 && !m_started) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic pulse_clr();
        cnt_clr = 1'b1;
        step();
        cnt_clr = 1'b0;
    endtask

    task automatic fill_phase(input logic [1:0] mode, input logic [7:0] val);
        wait_idle();
        cfg_pat_mode = mode;
        cfg_pat_val  = val;
        rdy_pct      = 70;
        cfg_fill_en  = 1'b1;
        for (int k = 0; k < 5; k++) begin
            write_cell(8'($urandom));
            repeat ($urandom % 120) step();
        end
        repeat (300) step();
        wait_idle();
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Main sequence
    initial begin
        void'($urandom(32'd20511));
        repeat (5) step();
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R4 reset valid", out_valid, 0);
        chk(wr_ready, "R1 reset ready", wr_ready, 1);
        mon_en = 1'b1;

        // filler off, buffer empty: output stays invalid (R4)
        repeat (20) step();

        // fill the buffer with the mapper stalled (R1)
        for (int c = 0; c < 4; c++) write_cell(8'(c));
        step();
        @(negedge clk);
        chk(!wr_ready, "R1 full", wr_ready, 0);
        chk(out_valid && !out_is_fill, "R2 first user", out_valid, 1);
        repeat (10) step();
        rdy_pct = 60;
        write_cell(8'hA5);
        wait_idle();
        @(negedge clk);
        chk(wr_ready, "R1 drained", wr_ready, 1);

        // filler pattern modes with interleaved user cells
        fill_phase(2'd0, 8'h6A);
        fill_phase(2'd1, 8'hFD);
        fill_phase(2'd2, 8'hF0);
        fill_phase(2'd3, 8'h00);

        // clear counters and per-cell step (R12)
        pulse_clr();
        @(negedge clk);
        chk(fill_cnt == 0 && user_cnt == 0, "R12 clear", fill_cnt + user_cnt, 0);
        fill_phase(2'd1, 8'h10);

        // wrap beyond all ones (R10)
        wait_idle();
        pulse_clr();
        cfg_cnt_sat  = 1'b0;
        cfg_pat_mode = 2'd0;
        rdy_pct      = 100;
        cfg_fill_en  = 1'b1;
        repeat (70 * 53) step();
        wait_idle();
        @(negedge clk);
        chk(int'(fill_cnt) == 70 - 64, "R10 wrap", fill_cnt, 70 - 64);

        // saturate at all ones (R11)
        pulse_clr();
        cfg_cnt_sat = 1'b1;
        cfg_fill_en = 1'b1;
        repeat (70 * 53) step();
        wait_idle();
        @(negedge clk);
        chk(int'(fill_cnt) == CMAX, "R11 saturate", fill_cnt, CMAX);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule